// File: doc/BRIEF.md
# Software Trap Exception Entry Unit

This unit sits beside the instruction decoder of a processor core that runs two instruction sets: a 32-bit set and a compact 16-bit set. It checks every valid instruction for the software trap encoding of the active set. On a match, it sequences the exception entry. First it asks the register file to switch into supervisor mode. In the following cycle it delivers everything that must land in that mode:
- the return link, written into the supervisor copy of register 14;
- the updated status word, with interrupts masked and the 32-bit state selected;
- a branch to the trap vector;
- a one-cycle pipeline flush, with a done strobe beside it.

The register banks, the trap handler and the return path live elsewhere. The unit only forms the requests and the values. All outputs are registered. One entry occupies three cycles: accept, switch and commit. While an entry is in flight, further trap matches are dropped.

Top module: `swi_entry_unit`

## Requirements
- R1: With `thumb_state` = 0, an instruction with `instr_valid` = 1 starts an entry when bits [11:8] of `idx_wide` are all ones, whatever bits [7:0] hold. Any other value of those four bits starts nothing.
- R2: With `thumb_state` = 1, an entry starts only when `idx_narrow` equals 8'hDF exactly. The neighbouring branch codes 8'hD0 to 8'hDE start nothing.
- R3: No entry starts in a cycle where `instr_valid` is 0, even when the index matches.
- R4: The cycle after an accepted instruction, `mode_req` is high for exactly one cycle and `mode_code` reads 5'b10011 (supervisor).
- R5: The cycle after `mode_req`, `lr_we` pulses for one cycle. `lr_value` then equals the `pc_in` of the accepted instruction minus 4, modulo 2^32. The link write never coincides with the mode request and always follows it.
- R6: In the `lr_we` cycle, `psr_we` pulses and `psr_value` equals the accepted `psr_in` with these changes:
  - bit 7 (interrupt mask) set to 1;
  - bits [4:0] set to 5'b10011;
  - bit 5 (state) cleared when the entry came from the 16-bit set, and kept otherwise.
  All other bits are unchanged.
- R7: In the `lr_we` cycle, `pc_we`, `flush` and `done` each pulse for one cycle, and `pc_value` equals 32'h00000008.
- R8: While `rst` is high, and in the first cycle after it, every strobe output is 0.
- R9: In the two cycles after an acceptance (the mode-request cycle and the commit cycle), a matching valid instruction starts no entry. A match in the cycle after the commit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | The decode index belongs to a live instruction |
| thumb_state | input | 1 | 1 = 16-bit set active, 0 = 32-bit set |
| idx_wide | input | 12 | Decode index of a 32-bit instruction |
| idx_narrow | input | 8 | Decode index of a 16-bit instruction |
| pc_in | input | 32 | Current program counter |
| psr_in | input | 32 | Current status word |
| mode_req | output | 1 | Mode-switch request pulse |
| mode_code | output | 5 | Requested mode code |
| lr_we | output | 1 | Link register write strobe |
| lr_value | output | 32 | Link value for register 14 |
| psr_we | output | 1 | Status word write strobe |
| psr_value | output | 32 | Updated status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_value | output | 32 | Trap vector address |
| flush | output | 1 | Pipeline flush pulse |
| done | output | 1 | Entry complete strobe |

## Verification
The assertions assume two things about the inputs. First, `rst` is held for at least one rising edge before the first instruction. Second, `pc_in` carries a known value in every cycle, because the link-value property looks back two cycles to the accepting edge. The stimulus drives every input to a defined value at each falling edge, from reset onward. It never leaves `pc_in` or `psr_in` undriven. This holds even in cycles where `instr_valid` is low or an entry is already in flight. The random part biases the indices toward the trap codes and the near-miss branch codes, so that accepted, dropped and ignored matches all occur often.

// File: rtl/swi_pkg.sv
package swi_pkg;

  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_SUPERVISOR = 5'b10011;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SWITCH = 2'd1,
    PH_COMMIT = 2'd2
  } swi_phase_e;

endpackage

// File: rtl/swi_match.sv
module swi_match #(
  parameter int               IDX_W       = 12,
  parameter logic [IDX_W-1:0] MATCH_MASK  = '1,
  parameter logic [IDX_W-1:0] MATCH_VALUE = '1
) (
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);

  localparam logic [IDX_W-1:0] MASKED_VALUE = MATCH_VALUE & MATCH_MASK;

  always_comb begin
    hit = ((idx & MATCH_MASK) == MASKED_VALUE);
  end

endmodule

// File: rtl/swi_seq.sv
module swi_seq
  import swi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trap_hit,
  output logic       accept,
  output swi_phase_e phase
);

  swi_phase_e phase_nxt;

  always_comb begin
    accept    = trap_hit && (phase == PH_IDLE);
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (accept) phase_nxt = PH_SWITCH;
      PH_SWITCH: phase_nxt = PH_COMMIT;
      PH_COMMIT: phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nxt;
  end

endmodule

// File: rtl/swi_commit.sv
module swi_commit
  import swi_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int PSR_W       = 32,
  parameter int LINK_OFFSET = 4,
  parameter int VECTOR_ADDR = 8,
  parameter int IRQ_BIT     = 7,
  parameter int STATE_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  swi_phase_e        phase,
  input  logic              from_narrow,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PSR_W-1:0]  psr_in,
  output logic              mode_req,
  output logic [MODE_W-1:0] mode_code,
  output logic              lr_we,
  output logic [PC_W-1:0]   lr_value,
  output logic              psr_we,
  output logic [PSR_W-1:0]  psr_value,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_value,
  output logic              flush,
  output logic              done
);

  localparam logic [PC_W-1:0] LINK_SUB = PC_W'(LINK_OFFSET);
  localparam logic [PC_W-1:0] VECTOR   = PC_W'(VECTOR_ADDR);

  logic [PC_W-1:0]  cap_link;
  logic [PSR_W-1:0] cap_psr;
  logic [PSR_W-1:0] psr_entry;
  logic             commit_now;

  // Status word as it must read inside the handler.
  always_comb begin
    psr_entry                = psr_in;
    psr_entry[MODE_W-1:0]    = MODE_SUPERVISOR;
    psr_entry[IRQ_BIT]       = 1'b1;
    if (from_narrow) psr_entry[STATE_BIT] = 1'b0;
  end

  always_comb begin
    commit_now = (phase == PH_SWITCH);
  end

  // Capture at acceptance; the instruction stream may move on afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_link <= '0;
      cap_psr  <= '0;
    end else if (accept) begin
      cap_link <= pc_in - LINK_SUB;
      cap_psr  <= psr_entry;
    end
  end

  // Phase one: request the supervisor bank.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_req  <= 1'b0;
      mode_code <= '0;
    end else begin
      mode_req  <= accept;
      mode_code <= accept ? MODE_SUPERVISOR : '0;
    end
  end

  // Phase two: write into the now-active supervisor bank and redirect.
  always_ff @(posedge clk) begin
    if (rst) begin
      lr_we     <= 1'b0;
      psr_we    <= 1'b0;
      pc_we     <= 1'b0;
      flush     <= 1'b0;
      done      <= 1'b0;
      lr_value  <= '0;
      psr_value <= '0;
      pc_value  <= '0;
    end else begin
      lr_we  <= commit_now;
      psr_we <= commit_now;
      pc_we  <= commit_now;
      flush  <= commit_now;
      done   <= commit_now;
      if (commit_now) begin
        lr_value  <= cap_link;
        psr_value <= cap_psr;
        pc_value  <= VECTOR;
      end
    end
  end

endmodule

// File: rtl/swi_entry_unit.sv
module swi_entry_unit
  import swi_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int PSR_W       = 32,
  parameter int WIDE_IDX_W  = 12,
  parameter int NARROW_IDX_W = 8,
  parameter int LINK_OFFSET = 4,
  parameter int VECTOR_ADDR = 8,
  parameter int IRQ_BIT     = 7,
  parameter int STATE_BIT   = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic                    thumb_state,
  input  logic [WIDE_IDX_W-1:0]   idx_wide,
  input  logic [NARROW_IDX_W-1:0] idx_narrow,
  input  logic [PC_W-1:0]         pc_in,
  input  logic [PSR_W-1:0]        psr_in,
  output logic                    mode_req,
  output logic [MODE_W-1:0]       mode_code,
  output logic                    lr_we,
  output logic [PC_W-1:0]         lr_value,
  output logic                    psr_we,
  output logic [PSR_W-1:0]        psr_value,
  output logic                    pc_we,
  output logic [PC_W-1:0]         pc_value,
  output logic                    flush,
  output logic                    done
);

  // Wide set: top nibble all ones. Narrow set: one exact code, which beats
  // the conditional-branch group sharing its upper nibble.
  localparam logic [WIDE_IDX_W-1:0] WIDE_MASK =
    {4'hF, {(WIDE_IDX_W-4){1'b0}}};
  localparam logic [NARROW_IDX_W-1:0] NARROW_MASK = '1;
  localparam logic [NARROW_IDX_W-1:0] NARROW_CODE = NARROW_IDX_W'(8'hDF);

  logic       wide_hit;
  logic       narrow_hit;
  logic       trap_hit;
  logic       accept;
  swi_phase_e phase;

  swi_match #(
    .IDX_W      (WIDE_IDX_W),
    .MATCH_MASK (WIDE_MASK),
    .MATCH_VALUE(WIDE_MASK)
  ) u_wide_match (
    .idx(idx_wide),
    .hit(wide_hit)
  );

  swi_match #(
    .IDX_W      (NARROW_IDX_W),
    .MATCH_MASK (NARROW_MASK),
    .MATCH_VALUE(NARROW_CODE)
  ) u_narrow_match (
    .idx(idx_narrow),
    .hit(narrow_hit)
  );

  always_comb begin
    trap_hit = instr_valid && (thumb_state ? narrow_hit : wide_hit);
  end

  swi_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .trap_hit(trap_hit),
    .accept  (accept),
    .phase   (phase)
  );

  swi_commit #(
    .PC_W       (PC_W),
    .PSR_W      (PSR_W),
    .LINK_OFFSET(LINK_OFFSET),
    .VECTOR_ADDR(VECTOR_ADDR),
    .IRQ_BIT    (IRQ_BIT),
    .STATE_BIT  (STATE_BIT)
  ) u_commit (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .phase      (phase),
    .from_narrow(thumb_state),
    .pc_in      (pc_in),
    .psr_in     (psr_in),
    .mode_req   (mode_req),
    .mode_code  (mode_code),
    .lr_we      (lr_we),
    .lr_value   (lr_value),
    .psr_we     (psr_we),
    .psr_value  (psr_value),
    .pc_we      (pc_we),
    .pc_value   (pc_value),
    .flush      (flush),
    .done       (done)
  );

endmodule

// File: rtl/swi_entry_chk.sv
module swi_entry_chk #(
  parameter int PC_W        = 32,
  parameter int PSR_W       = 32,
  parameter int LINK_OFFSET = 4,
  parameter int VECTOR_ADDR = 8,
  parameter int IRQ_BIT     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_valid,
  input logic [PC_W-1:0]  pc_in,
  input logic             mode_req,
  input logic [4:0]       mode_code,
  input logic             lr_we,
  input logic [PC_W-1:0]  lr_value,
  input logic             psr_we,
  input logic [PSR_W-1:0] psr_value,
  input logic             pc_we,
  input logic [PC_W-1:0]  pc_value,
  input logic             flush,
  input logic             done
);

  AST_ENTRY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    mode_req |-> $past(instr_valid)); // R3

  AST_MODE_IS_SUPERVISOR: assert property (@(posedge clk) disable iff (rst)
    mode_req |-> (mode_code == 5'b10011)); // R4

  AST_MODE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mode_req |=> !mode_req); // R4

  AST_LINK_AFTER_SWITCH: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> ($past(mode_req) && !mode_req)); // R5

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> (lr_value == $past(pc_in, 2) - PC_W'(LINK_OFFSET))); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    psr_we |-> (psr_value[IRQ_BIT] && psr_value[4:0] == 5'b10011)); // R6

  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (pc_value == PC_W'(VECTOR_ADDR))); // R7

  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    flush |-> (done && pc_we && lr_we && psr_we)); // R7

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    mode_req |=> !mode_req ##1 !mode_req); // R9

endmodule

bind swi_entry_unit swi_entry_chk #(
  .PC_W       (PC_W),
  .PSR_W      (PSR_W),
  .LINK_OFFSET(LINK_OFFSET),
  .VECTOR_ADDR(VECTOR_ADDR),
  .IRQ_BIT    (IRQ_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr_valid(instr_valid),
  .pc_in      (pc_in),
  .mode_req   (mode_req),
  .mode_code  (mode_code),
  .lr_we      (lr_we),
  .lr_value   (lr_value),
  .psr_we     (psr_we),
  .psr_value  (psr_value),
  .pc_we      (pc_we),
  .pc_value   (pc_value),
  .flush      (flush),
  .done       (done)
);

// File: tb/tb_swi_entry_unit.sv
`timescale 1ns/1ps
module tb_swi_entry_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic        thumb_state;
  logic [11:0] idx_wide;
  logic [7:0]  idx_narrow;
  logic [31:0] pc_in;
  logic [31:0] psr_in;
  logic        mode_req;
  logic [4:0]  mode_code;
  logic        lr_we;
  logic [31:0] lr_value;
  logic        psr_we;
  logic [31:0] psr_value;
  logic        pc_we;
  logic [31:0] pc_value;
  logic        flush;
  logic        done;

  always #2 clk = ~clk;

  swi_entry_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .thumb_state(thumb_state),
    .idx_wide(idx_wide), .idx_narrow(idx_narrow), .pc_in(pc_in), .psr_in(psr_in),
    .mode_req(mode_req), .mode_code(mode_code), .lr_we(lr_we), .lr_value(lr_value),
    .psr_we(psr_we), .psr_value(psr_value), .pc_we(pc_we), .pc_value(pc_value),
    .flush(flush), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  bit          exp_mode = 0;
  bit          exp_commit = 0;
  int          busy = 0;
  logic [31:0] pend_lr = '0, pend_psr = '0;
  logic [31:0] exp_lr = '0, exp_psr = '0;
  string       mode_tag = "R1";

  function automatic bit is_trap(bit th, logic [11:0] iw, logic [7:0] in8);
    if (th) return in8 == 8'hDF;
    return iw[11:8] == 4'b1111;
  endfunction

  function automatic logic [31:0] entry_psr(logic [31:0] p, bit th);
    logic [31:0] r = p;
    r[4:0] = 5'b10011;
    r[7]   = 1'b1;
    if (th) r[5] = 1'b0;
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(mode_tag, "mode_req", 32'(mode_req), 32'(exp_mode));
    if (exp_mode) chk("R4", "mode_code", 32'(mode_code), 32'h13);
    chk("R5", "lr_we", 32'(lr_we), 32'(exp_commit));
    chk("R6", "psr_we", 32'(psr_we), 32'(exp_commit));
    chk("R7", "pc_we", 32'(pc_we), 32'(exp_commit));
    chk("R7", "flush", 32'(flush), 32'(exp_commit));
    chk("R7", "done", 32'(done), 32'(exp_commit));
    if (exp_commit) begin
      chk("R5", "lr_value", lr_value, exp_lr);
      chk("R6", "psr_value", psr_value, exp_psr);
      chk("R7", "pc_value", pc_value, 32'h8);
    end
  endtask

  task automatic cycle(bit v, bit th, logic [11:0] iw, logic [7:0] in8,
                       logic [31:0] pc, logic [31:0] psr);
    bit acc;
    instr_valid = v; thumb_state = th; idx_wide = iw; idx_narrow = in8;
    pc_in = pc; psr_in = psr;
    acc = (busy == 0) && v && is_trap(th, iw, in8);
    if (!v) mode_tag = "R3";
    else if (busy != 0) mode_tag = "R9";
    else mode_tag = th ? "R2" : "R1";
    exp_commit = exp_mode;
    if (exp_mode) begin
      exp_lr  = pend_lr;
      exp_psr = pend_psr;
    end
    if (acc) begin
      pend_lr  = pc - 32'd4;
      pend_psr = entry_psr(psr, th);
    end
    exp_mode = acc;
    if (acc) busy = 2;
    else if (busy > 0) busy--;
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst = 1; instr_valid = 0; thumb_state = 0; idx_wide = '0; idx_narrow = '0;
    pc_in = '0; psr_in = '0;
    repeat (3) @(negedge clk);
    // R8: reset holds every strobe low
    chk("R8", "mode_req", 32'(mode_req), 0);
    chk("R8", "lr_we", 32'(lr_we), 0);
    chk("R8", "flush", 32'(flush), 0);
    chk("R8", "done", 32'(done), 0);
    rst = 0;
    cycle(0, 0, 12'h000, 8'h00, 32'h100, 32'h1F);   // R8 first cycle after reset
    // R1: wide trap, low bits arbitrary
    cycle(1, 0, 12'hF3A, 8'h00, 32'h0800_0010, 32'h6000_00DF);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    // R1: near miss 1110
    cycle(1, 0, 12'hEFF, 8'h00, 32'h200, 32'h0);
    // R2: branch codes around the trap code must not enter
    cycle(1, 1, 12'hFFF, 8'hDE, 32'h300, 32'h3F);
    cycle(1, 1, 12'hFFF, 8'hD0, 32'h300, 32'h3F);
    // R3: matching but not valid
    cycle(0, 1, 12'h000, 8'hDF, 32'h300, 32'h3F);
    // R2 + R6: narrow trap clears state bit; R5 link wraps below zero
    cycle(1, 1, 12'h000, 8'hDF, 32'h0000_0002, 32'hF000_003F);
    // R9: matches during switch and commit are dropped
    cycle(1, 1, 12'h000, 8'hDF, 32'h400, 32'h3F);
    cycle(1, 0, 12'hF00, 8'h00, 32'h404, 32'h1F);
    // R9: accepted again right after the commit
    cycle(1, 0, 12'hFFF, 8'h00, 32'h500, 32'h0000_00B0);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit v, th;
      logic [11:0] iw;
      logic [7:0] in8;
      int sel;
      v  = ($urandom % 10) < 7;
      th = $urandom % 2;
      iw = 12'($urandom);
      if (($urandom % 10) < 3) iw[11:8] = 4'hF;
      sel = $urandom % 10;
      if (sel < 3) in8 = 8'hDF;
      else if (sel < 6) in8 = 8'hD0 | 8'($urandom % 15);
      else in8 = 8'($urandom);
      cycle(v, th, iw, in8, $urandom, $urandom);
    end
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    cycle(0, 0, 12'h000, 8'h00, 32'h0, 32'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule